// File: doc/BRIEF.md
# Four-Port Crosspoint-Queued Word Switch

This block moves 24-bit words from any of four input ports to any of four output ports. Every input port carries a 2-bit output number and a valid flag with each word, so one input can send consecutive words to different outputs on consecutive cycles. Every pairing of an input with an output has its own eight-entry queue, which gives sixteen queues in all. A word is written only into the queue for its own input and its own output. Traffic from several inputs that converges on one output therefore waits in separate queues and does not block traffic from those inputs to other outputs.

On the pins, each word travels as two 12-bit halves in one clock period. The low half comes with the rising edge and the high half with the falling edge. This applies to the inputs and to the outputs. Each output has a round-robin arbiter that takes at most one word per cycle from its four queues. An input whose target queue has no room drops its ready line, and the sender keeps presenting the same word until ready comes back.

Top module: `xbar_switch4`

## Requirements
- R1: After reset, every `in_rdy_o` bit is 1, every `out_vld_o` bit is 0, all sixteen queues are empty and every arbiter pointer selects input 0.
- R2: An input samples `in_dest_i`, `in_vld_i` and the low half (word bits 11:0) on a rising clock edge. It samples the high half (word bits 23:12) on the falling edge that follows.
- R3: A word accepted on input i with output number j appears only on output j, with all 24 bits unchanged.
- R4: Words on one input-to-output path leave in the order they were accepted. No accepted word is lost or duplicated, and no queue is read while it is empty.
- R5: A cycle with `in_vld_i` low writes nothing, whatever the data and output-number pins carry.
- R6: `in_rdy_o[i]` is low when queue (i, dest) would hold eight words once the word captured in the previous cycle is counted. A word offered while ready is low is not taken, and the sender must hold it.
- R7: A full queue lowers ready only for the input that feeds it, and only while that input addresses that output. Traffic from the same input to another output continues at full rate.
- R8: Each output serves its non-empty queues in round-robin order. After serving input g, input g+1 (modulo 4) has the highest priority. Under full contention right after reset, the sources come out as 0,1,2,3,0,...
- R9: Each output issues at most one word per cycle, and it issues one in every cycle in which any of its queues is non-empty.
- R10: Without conflicts, a word accepted at rising edge k shows up on its output right after rising edge k+2. Every port then carries one word per clock period and ready stays high.
- R11: An output raises `out_vld_o` and drives the low half after a rising edge, then drives the high half after the following falling edge.
- R12: Consecutive words from one input with different output numbers each go to their own output, with the same two-cycle latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Port clock; both edges carry data |
| rst_ni | input | 1 | Active-low reset, asserted asynchronously and released synchronously inside |
| in_half_i | input | 48 | Four 12-bit input halves, port p at bits 12p+11:12p |
| in_dest_i | input | 8 | Four 2-bit output numbers, port p at bits 2p+1:2p |
| in_vld_i | input | 4 | Per-input word valid, sampled on the rising edge |
| in_rdy_o | output | 4 | Per-input ready; low means the addressed queue is full |
| out_half_o | output | 48 | Four 12-bit output halves, low half after rise, high half after fall |
| out_vld_o | output | 4 | Per-output word valid for the current clock period |

## Verification
The hardest state to reach is the one where three inputs keep one output's queues full while a fourth input streams to another output. Only there do backpressure, round-robin fairness among full queues and per-pair independence all act at once. The stimulus reaches it with a directed phase in which inputs 1 to 3 send to output 1 and hold any word that is refused, while input 0 sends to output 2. After the queues have filled, a measured window counts accepted words per input and ready-low cycles. A constrained-random phase with held words then mixes output numbers freely. Its words carry their source, output number and a sequence number, so that order, loss and duplication are checked per path.

// File: rtl/xbar_pkg.sv
package xbar_pkg;
  localparam int unsigned DEF_PORTS  = 4;
  localparam int unsigned DEF_HALF_W = 12;
  localparam int unsigned DEF_DEPTH  = 8;
endpackage

// File: rtl/xbar_rst_sync.sv
module xbar_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_no = sync_q[1];
endmodule

// File: rtl/xbar_fifo.sv
module xbar_fifo #(
  parameter int unsigned W     = 24,
  parameter int unsigned DEPTH = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         rd_i,
  output logic [W-1:0] rdata_o,
  output logic         empty_o,
  output logic         full_o,
  output logic         afull_o
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] cnt_q;

  function automatic logic [AW-1:0] ptr_nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (wr_i) wr_ptr_q <= ptr_nxt(wr_ptr_q);
      if (rd_i) rd_ptr_q <= ptr_nxt(rd_ptr_q);
      case ({wr_i, rd_i})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_i) mem_q[wr_ptr_q] <= wdata_i;
  end

  assign rdata_o = mem_q[rd_ptr_q];
  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign afull_o = (cnt_q >= CW'(DEPTH - 1));
endmodule

// File: rtl/xbar_ddr_in.sv
module xbar_ddr_in #(
  parameter int unsigned N      = 4,
  parameter int unsigned HALF_W = 12,
  localparam int unsigned DW    = $clog2(N)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [HALF_W-1:0]   half_i,
  input  logic [DW-1:0]       dest_i,
  input  logic                vld_i,
  input  logic [N-1:0]        row_full_i,
  input  logic [N-1:0]        row_afull_i,
  output logic                rdy_o,
  output logic [N-1:0]        wr_o,
  output logic [2*HALF_W-1:0] word_o
);
  logic [HALF_W-1:0] lo_q, hi_q;
  logic [DW-1:0]     dest_q;
  logic              pend_q;
  logic              tgt_full, tgt_afull, hit;

  always_comb begin
    tgt_full  = 1'b0;
    tgt_afull = 1'b0;
    for (int j = 0; j < int'(N); j++) begin
      if (dest_i == DW'(j)) begin
        tgt_full  = row_full_i[j];
        tgt_afull = row_afull_i[j];
      end
    end
  end

  // the staged word still counts against its queue
  assign hit   = pend_q && (dest_q == dest_i);
  assign rdy_o = !(tgt_full || (hit && tgt_afull));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      lo_q   <= '0;
      dest_q <= '0;
    end else begin
      pend_q <= vld_i && rdy_o;
      if (vld_i && rdy_o) begin
        lo_q   <= half_i;
        dest_q <= dest_i;
      end
    end
  end

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     hi_q <= '0;
    else if (pend_q) hi_q <= half_i;
  end

  for (genvar j = 0; j < N; j++) begin : g_wr
    assign wr_o[j] = pend_q && (dest_q == DW'(j));
  end

  assign word_o = {hi_q, lo_q};
endmodule

// File: rtl/xbar_rr_arb.sv
module xbar_rr_arb #(
  parameter int N = 4,
  localparam int IW = $clog2(N)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] req_i,
  output logic [N-1:0] gnt_o
);
  logic [IW-1:0] ptr_q, gidx;
  logic          any;
  int            idx;

  always_comb begin
    gnt_o = '0;
    any   = 1'b0;
    gidx  = '0;
    idx   = 0;
    for (int off = 0; off < N; off++) begin
      idx = (int'(ptr_q) + off) % N;
      if (!any && req_i[idx]) begin
        gnt_o[idx] = 1'b1;
        any        = 1'b1;
        gidx       = IW'(idx);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  ptr_q <= '0;
    else if (any) ptr_q <= (gidx == IW'(N - 1)) ? '0 : gidx + IW'(1);
  end
endmodule

// File: rtl/xbar_ddr_out.sv
module xbar_ddr_out #(
  parameter int unsigned HALF_W = 12
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                vld_i,
  input  logic [2*HALF_W-1:0] word_i,
  output logic [HALF_W-1:0]   half_o,
  output logic                vld_o
);
  logic [HALF_W-1:0] pos_q, neg_q, hi_stage_q, lo_d, hi_d;

  assign lo_d = vld_i ? word_i[HALF_W-1:0]        : '0;
  assign hi_d = vld_i ? word_i[2*HALF_W-1:HALF_W] : '0;

  // pin = pos_q ^ neg_q: each edge flips in its own half
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q      <= '0;
      hi_stage_q <= '0;
      vld_o      <= 1'b0;
    end else begin
      pos_q      <= lo_d ^ neg_q;
      hi_stage_q <= hi_d;
      vld_o      <= vld_i;
    end
  end

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) neg_q <= '0;
    else         neg_q <= hi_stage_q ^ pos_q;
  end

  assign half_o = pos_q ^ neg_q;
endmodule

// File: rtl/xbar_switch4.sv
module xbar_switch4
  import xbar_pkg::*;
#(
  parameter int unsigned N_PORTS = DEF_PORTS,
  parameter int unsigned HALF_W  = DEF_HALF_W,
  parameter int unsigned DEPTH   = DEF_DEPTH,
  localparam int unsigned DW     = $clog2(N_PORTS)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [N_PORTS*HALF_W-1:0]   in_half_i,
  input  logic [N_PORTS*DW-1:0]       in_dest_i,
  input  logic [N_PORTS-1:0]          in_vld_i,
  output logic [N_PORTS-1:0]          in_rdy_o,
  output logic [N_PORTS*HALF_W-1:0]   out_half_o,
  output logic [N_PORTS-1:0]          out_vld_o
);
  localparam int unsigned WORD_W = 2 * HALF_W;
  localparam int unsigned NN     = N_PORTS * N_PORTS;

  logic              rst_n;
  logic [NN-1:0]     fifo_wr, fifo_rd, fifo_full, fifo_afull, fifo_empty;
  logic [WORD_W-1:0] in_word   [N_PORTS];
  logic [WORD_W-1:0] fifo_dout [NN];
  logic [N_PORTS-1:0] col_gnt  [N_PORTS];

  xbar_rst_sync u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n)
  );

  for (genvar i = 0; i < N_PORTS; i++) begin : g_in
    xbar_ddr_in #(.N(N_PORTS), .HALF_W(HALF_W)) u_in (
      .clk_i       (clk_i),
      .rst_ni      (rst_n),
      .half_i      (in_half_i[i*HALF_W +: HALF_W]),
      .dest_i      (in_dest_i[i*DW +: DW]),
      .vld_i       (in_vld_i[i]),
      .row_full_i  (fifo_full[i*N_PORTS +: N_PORTS]),
      .row_afull_i (fifo_afull[i*N_PORTS +: N_PORTS]),
      .rdy_o       (in_rdy_o[i]),
      .wr_o        (fifo_wr[i*N_PORTS +: N_PORTS]),
      .word_o      (in_word[i])
    );
  end

  // queue (i,j) sits at index i*N_PORTS+j
  for (genvar i = 0; i < N_PORTS; i++) begin : g_row
    for (genvar j = 0; j < N_PORTS; j++) begin : g_col
      localparam int unsigned K = i * N_PORTS + j;
      xbar_fifo #(.W(WORD_W), .DEPTH(DEPTH)) u_fifo (
        .clk_i   (clk_i),
        .rst_ni  (rst_n),
        .wr_i    (fifo_wr[K]),
        .wdata_i (in_word[i]),
        .rd_i    (fifo_rd[K]),
        .rdata_o (fifo_dout[K]),
        .empty_o (fifo_empty[K]),
        .full_o  (fifo_full[K]),
        .afull_o (fifo_afull[K])
      );
    end
  end

  for (genvar j = 0; j < N_PORTS; j++) begin : g_out
    logic [N_PORTS-1:0] req;
    logic [WORD_W-1:0]  sel;

    for (genvar i = 0; i < N_PORTS; i++) begin : g_src
      assign req[i]                 = !fifo_empty[i*N_PORTS+j];
      assign fifo_rd[i*N_PORTS+j]   = col_gnt[j][i];
    end

    xbar_rr_arb #(.N(N_PORTS)) u_arb (
      .clk_i  (clk_i),
      .rst_ni (rst_n),
      .req_i  (req),
      .gnt_o  (col_gnt[j])
    );

    always_comb begin
      sel = '0;
      for (int i = 0; i < int'(N_PORTS); i++) begin
        if (col_gnt[j][i]) sel = sel | fifo_dout[i*N_PORTS+j];
      end
    end

    xbar_ddr_out #(.HALF_W(HALF_W)) u_out (
      .clk_i  (clk_i),
      .rst_ni (rst_n),
      .vld_i  (|col_gnt[j]),
      .word_i (sel),
      .half_o (out_half_o[j*HALF_W +: HALF_W]),
      .vld_o  (out_vld_o[j])
    );
  end
endmodule

// File: rtl/xbar_switch4_chk.sv
module xbar_switch4_chk #(
  parameter int unsigned N = 4
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic [N-1:0]   in_vld_i,
  input logic [N-1:0]   in_rdy_i,
  input logic [N*N-1:0] wr_i,
  input logic [N*N-1:0] full_i,
  input logic [N*N-1:0] rd_i,
  input logic [N*N-1:0] empty_i
);
  // R6
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i & full_i) == '0);

  // R4
  no_underflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i & empty_i) == '0);

  for (genvar i = 0; i < N; i++) begin : g_in
    // R6
    hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(in_vld_i[i] && in_rdy_i[i]) |=> (wr_i[i*N +: N] == '0));
  end

  for (genvar j = 0; j < N; j++) begin : g_col
    logic [N-1:0] req, gnt, rot;
    for (genvar i = 0; i < N; i++) begin : g_src
      assign req[i] = !empty_i[i*N+j];
      assign gnt[i] = rd_i[i*N+j];
    end
    assign rot = {gnt[N-2:0], gnt[N-1]};

    // R9
    one_pop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(gnt));

    // R9
    serve_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|req) |-> (|gnt));

    // R8
    rr_turn_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((&req) && $past(&req)) |-> (gnt == $past(rot)));
  end
endmodule

bind xbar_switch4 xbar_switch4_chk #(.N(N_PORTS)) chk_i (
  .clk_i    (clk_i),
  .rst_ni   (rst_n),
  .in_vld_i (in_vld_i),
  .in_rdy_i (in_rdy_o),
  .wr_i     (fifo_wr),
  .full_i   (fifo_full),
  .rd_i     (fifo_rd),
  .empty_i  (fifo_empty)
);

// File: tb/xbar_switch4_tb_top.sv
module xbar_switch4_tb_top;
  localparam int N  = 4;
  localparam int HW = 12;
  localparam int WW = 24;
  localparam int DW = 2;

  logic clk = 1'b0;
  logic rst_n;
  logic [N*HW-1:0] in_half, out_half;
  logic [N*DW-1:0] in_dest;
  logic [N-1:0]    in_vld, in_rdy, out_vld;

  always #4 clk = ~clk;

  xbar_switch4 dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .in_half_i  (in_half),
    .in_dest_i  (in_dest),
    .in_vld_i   (in_vld),
    .in_rdy_o   (in_rdy),
    .out_half_o (out_half),
    .out_vld_o  (out_vld)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int seq = 0;
  int total_out = 0;
  int rr_idx = 0;
  bit lat_mode = 0;
  bit rr_mode = 0;
  int out_cnt [N];
  int acc_cnt [N];
  int rdy_low [N];
  logic [WW-1:0] sb_w [N*N][$];
  int            sb_t [N*N][$];
  logic [N-1:0]  cur_vld;
  logic [WW-1:0] cur_w [N];
  logic [N-1:0]  acc;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // word layout used by the bench: [23:22] source, [21:20] output, [19:0] sequence
  function automatic logic [WW-1:0] make_word(input int s, input int d);
    logic [WW-1:0] w;
    w = {s[1:0], d[1:0], seq[19:0]};
    seq++;
    return w;
  endfunction

  task automatic offer(input int i, input int d);
    cur_vld[i] = 1'b1;
    cur_w[i]   = make_word(i, d);
  endtask

  // entered at falling edge + 1
  task automatic step();
    for (int i = 0; i < N; i++) begin
      in_half[i*HW +: HW] = cur_w[i][HW-1:0];
      in_dest[i*DW +: DW] = cur_w[i][21:20];
      in_vld[i]           = cur_vld[i];
    end
    #2;
    for (int i = 0; i < N; i++) begin
      acc[i] = cur_vld[i] && in_rdy[i];
      if (!in_rdy[i]) rdy_low[i]++;
      if (acc[i]) begin
        sb_w[i*N + int'(cur_w[i][21:20])].push_back(cur_w[i]);
        sb_t[i*N + int'(cur_w[i][21:20])].push_back(cyc + 1);
        acc_cnt[i]++;
      end
    end
    @(posedge clk);
    #1;
    for (int i = 0; i < N; i++) in_half[i*HW +: HW] = cur_w[i][WW-1:HW];
    @(negedge clk);
    #1;
  endtask

  task automatic idle(input int n);
    cur_vld = '0;
    repeat (n) step();
  endtask

  task automatic clear_stats();
    for (int i = 0; i < N; i++) begin
      out_cnt[i] = 0;
      acc_cnt[i] = 0;
      rdy_low[i] = 0;
    end
  endtask

  // output monitor
  initial begin
    logic [N-1:0]    v;
    logic [N*HW-1:0] lo, hi;
    logic [WW-1:0]   w, ew;
    int tnow, et, s, d, k;
    forever begin
      @(posedge clk);
      #2;
      v    = out_vld;
      lo   = out_half;
      tnow = cyc;
      @(negedge clk);
      #2;
      hi = out_half;
      for (int j = 0; j < N; j++) begin
        if (v[j]) begin
          w = {hi[j*HW +: HW], lo[j*HW +: HW]};
          total_out++;
          out_cnt[j]++;
          s = int'(w[23:22]);
          d = int'(w[21:20]);
          k = s*N + j;
          chk(d == j, "R3 word on wrong output", j, d);
          if (sb_w[k].size() == 0) begin
            chk(1'b0, "R4 unexpected or duplicated word", int'(w), 0);
          end else begin
            ew = sb_w[k].pop_front();
            et = sb_t[k].pop_front();
            chk(w == ew, "R4 R2 R11 path order and half assembly", int'(w), int'(ew));
            if (lat_mode) chk(tnow - et == 2, "R10 latency cycles", tnow - et, 2);
          end
          if (rr_mode && j == 0) begin
            chk(s == rr_idx % 4, "R8 round-robin source", s, rr_idx % 4);
            rr_idx++;
          end
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired act=0 exp=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int base, sd, lo_ok;
    sd = $urandom(32'd7);
    rst_n   = 1'b0;
    in_half = '0;
    in_dest = '0;
    in_vld  = '0;
    cur_vld = '0;
    acc     = '0;
    for (int i = 0; i < N; i++) cur_w[i] = '0;
    clear_stats();
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;

    // R1 reset state
    chk(in_rdy == 4'hF, "R1 ready after reset", int'(in_rdy), 15);
    chk(out_vld == 4'h0, "R1 no output after reset", int'(out_vld), 0);

    // R8 full contention on output 0 right after reset
    rr_mode = 1;
    for (int c = 0; c < 4; c++) begin
      for (int i = 0; i < N; i++) offer(i, 0);
      step();
    end
    idle(20);
    rr_mode = 0;
    chk(rr_idx == 16, "R8 words served under contention", rr_idx, 16);

    // R5 valid low with toggling pins
    base = total_out;
    for (int c = 0; c < 10; c++) begin
      for (int i = 0; i < N; i++) begin
        cur_vld[i] = 1'b0;
        cur_w[i]   = WW'($urandom);
      end
      step();
    end
    idle(4);
    chk(total_out == base, "R5 words from invalid cycles", total_out - base, 0);

    // R10 conflict-free permutation at full rate
    clear_stats();
    lat_mode = 1;
    for (int c = 0; c < 20; c++) begin
      for (int i = 0; i < N; i++) offer(i, (i + 1) % N);
      step();
    end
    idle(4);
    lat_mode = 0;
    for (int i = 0; i < N; i++) begin
      chk(rdy_low[i] == 0, "R10 ready dropped without conflict", rdy_low[i], 0);
      chk(out_cnt[i] == 20, "R10 words per output", out_cnt[i], 20);
    end

    // R12 one input cycling through all outputs
    clear_stats();
    lat_mode = 1;
    for (int c = 0; c < 8; c++) begin
      cur_vld = '0;
      offer(0, c % N);
      step();
    end
    idle(4);
    lat_mode = 0;
    for (int j = 0; j < N; j++)
      chk(out_cnt[j] == 2, "R12 per-cycle routing count", out_cnt[j], 2);

    // R6 R7 R9 saturation: inputs 1..3 to output 1, input 0 to output 2
    acc = '0;
    cur_vld = '0;
    for (int c = 0; c < 65; c++) begin
      if (c == 20) clear_stats();
      for (int i = 0; i < N; i++)
        if (!cur_vld[i] || acc[i]) offer(i, (i == 0) ? 2 : 1);
      step();
    end
    chk(rdy_low[0] == 0, "R7 ready on unaffected pair", rdy_low[0], 0);
    chk(acc_cnt[0] == 45, "R7 full rate on other output", acc_cnt[0], 45);
    chk(out_cnt[1] == 45, "R9 output busy every cycle", out_cnt[1], 45);
    for (int i = 1; i < N; i++) begin
      chk(rdy_low[i] > 0, "R6 backpressure seen", rdy_low[i], 1);
      lo_ok = (acc_cnt[i] >= 14 && acc_cnt[i] <= 16) ? 1 : 0;
      chk(lo_ok == 1, "R8 fair share under contention", acc_cnt[i], 15);
    end
    idle(40);

    // R3 R4 R6 random traffic with held words
    acc = '0;
    cur_vld = '0;
    for (int c = 0; c < 400; c++) begin
      for (int i = 0; i < N; i++) begin
        if (!cur_vld[i] || acc[i]) begin
          if ($urandom % 10 < 7) offer(i, int'($urandom % 4));
          else cur_vld[i] = 1'b0;
        end
      end
      step();
    end
    idle(60);

    for (int k = 0; k < N*N; k++)
      chk(sb_w[k].size() == 0, "R4 words left undelivered", sb_w[k].size(), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule